// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether one memory access may proceed against a page whose table entry has already been fetched. It receives the kind of access (instruction fetch, data load or data store), whether the requester runs unprivileged, the two segment key bits, and the entry's no-execute, guarded, protection-code and class-key fields. It also receives a data key-mask word and an instruction key-mask word. From these it forms three independent read/write/execute sets: a guard source, an authority source and a class-key source.

The allowed set is the bitwise AND of the three sources. The access is granted when the bit it needs is present in that set. On a deny, a cause word tells the fault handler which source refused the access. Fetch faults and data faults use different cause rules. The result is registered and valid for one cycle, one clock after the request.

Top module: `page_perm_check`

## Requirements
- R1: When `req_valid` is sampled high at a clock edge, `rsp_valid` is high together with that request's `perm`, `grant` and `cause` after that edge, and low in every other cycle. After reset all outputs are zero.
- R2: If `pte_noexec` or `pte_guard` is set, the guard source allows only read and write (perm bits: bit 0 read, bit 1 write, bit 2 execute). Otherwise it allows all three.
- R3: The authority key is `seg_key_user` when `user_mode` is 1 and `seg_key_sup` when it is 0. The protection code is {`pte_pp_hi`, `pte_pp[1:0]`}.
- R4: With authority key 0, codes 0, 1, 2 and 6 allow read/write/execute, codes 3 and 5 allow read/execute, and codes 4 and 7 allow nothing.
- R5: With authority key 1, codes 0 and 6 allow nothing, codes 1, 3 and 5 allow read/execute, code 2 allows read/write/execute, and codes 4 and 7 allow nothing.
- R6: For class key k, the data-mask field starts at bit 2*(31-k). Field bit 1 (absolute bit 2*(31-k)+1) removes write, and field bit 0 removes read. The data mask never touches execute.
- R7: Bit 2*(31-k) of the instruction mask removes execute, but only while `imask_en` is 1. When `imask_en` is 0, the instruction mask has no effect.
- R8: `perm` is the AND of the three sources. `acc_type` is encoded as 0 fetch (needs execute), 1 load (needs read), 2 store (needs write), and 3 is treated as a load. `grant` is 1 exactly when the needed bit is set in `perm`.
- R9: On a denied fetch, cause bit 0 (no-exec/guard) is set if the guard source lacks execute. Otherwise cause bit 1 (authority) is set if the authority source lacks execute. Cause bit 2 (key) is set whenever the key source lacks execute. Cause bit 3 stays 0.
- R10: On a denied load or store, bit 1 is set if the authority source lacks the needed bit, and bit 2 is set if the key source lacks it. Bit 3 (store) is set for stores. A granted access reports cause 0.
- R11: With parameter `KEY_EN` = 0, the key source allows everything, whatever the masks hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| user_mode | input | 1 | Requester is unprivileged |
| seg_key_sup | input | 1 | Segment key used when privileged |
| seg_key_user | input | 1 | Segment key used when unprivileged |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| pte_pp | input | 2 | Entry low protection bits |
| pte_pp_hi | input | 1 | Entry high protection bit |
| pte_ckey | input | 5 | Entry class key |
| dmask | input | 64 | Data key-mask word |
| imask | input | 64 | Instruction key-mask word |
| imask_en | input | 1 | Enables the instruction mask |
| rsp_valid | output | 1 | Result valid |
| perm | output | 3 | Allowed set: bit 0 read, 1 write, 2 execute |
| grant | output | 1 | Access allowed |
| cause | output | 4 | bit 0 no-exec/guard, 1 authority, 2 key, 3 store |

## Verification
Every result appears on the first clock edge after its request, because a single register stage sits between the inputs and the outputs. The bench drives each request on a falling edge and records the cycle count at which the answer is due. The monitor samples on each later falling edge. It expects `rsp_valid` high with the queued values exactly when the cycle count matches the head of the queue, and `rsp_valid` low otherwise. A second instance with the key source disabled gets the same stimulus and is compared in the same cycle.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int PERM_W  = 3;
    localparam int CAUSE_W = 4;

    localparam int P_RD = 0;
    localparam int P_WR = 1;
    localparam int P_EX = 2;

    localparam int C_NXG   = 0;
    localparam int C_AUTH  = 1;
    localparam int C_KEY   = 2;
    localparam int C_STORE = 3;

    localparam logic [PERM_W-1:0] PERM_NONE = 3'b000;
    localparam logic [PERM_W-1:0] PERM_RX   = 3'b101;
    localparam logic [PERM_W-1:0] PERM_RW   = 3'b011;
    localparam logic [PERM_W-1:0] PERM_ALL  = 3'b111;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        logic               valid;
        logic [PERM_W-1:0]  perm;
        logic               grant;
        logic [CAUSE_W-1:0] cause;
    } result_t;
endpackage

// File: rtl/pac_guard_src.sv
module pac_guard_src
    import pac_pkg::*;
(
    input  logic              noexec,
    input  logic              guarded,
    output logic [PERM_W-1:0] allow
);
    always_comb begin
        allow = PERM_ALL;
        if (noexec || guarded) allow = PERM_RW;
    end
endmodule

// File: rtl/pac_auth_src.sv
module pac_auth_src
    import pac_pkg::*;
(
    input  logic              user_mode,
    input  logic              key_sup,
    input  logic              key_user,
    input  logic [2:0]        code,
    output logic [PERM_W-1:0] allow
);
    logic eff_key;

    always_comb begin
        eff_key = user_mode ? key_user : key_sup;
        allow   = PERM_NONE;
        if (!eff_key) begin
            unique case (code)
                3'd0, 3'd1, 3'd2, 3'd6: allow = PERM_ALL;
                3'd3, 3'd5:             allow = PERM_RX;
                default:                allow = PERM_NONE;
            endcase
        end else begin
            unique case (code)
                3'd2:             allow = PERM_ALL;
                3'd1, 3'd3, 3'd5: allow = PERM_RX;
                default:          allow = PERM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pac_key_src.sv
module pac_key_src
    import pac_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    parameter bit KEY_EN   = 1'b1,
    localparam int KEY_W   = $clog2(NUM_KEYS),
    localparam int MASK_W  = 2 * NUM_KEYS,
    localparam int IDX_W   = KEY_W + 1
) (
    input  logic [KEY_W-1:0]  ckey,
    input  logic [MASK_W-1:0] dmask,
    input  logic [MASK_W-1:0] imask,
    input  logic              imask_en,
    output logic [PERM_W-1:0] allow
);
    generate
        if (KEY_EN) begin : g_keyed
            logic [IDX_W-1:0] base;
            logic [1:0]       dfield;
            logic             ibit;
            always_comb begin
                // field for key k sits at 2*(NUM_KEYS-1-k); ~k equals NUM_KEYS-1-k
                base   = {~ckey, 1'b0};
                dfield = dmask[base +: 2];
                ibit   = imask[base];
                allow  = PERM_ALL;
                if (dfield[1])           allow[P_WR] = 1'b0;
                if (dfield[0])           allow[P_RD] = 1'b0;
                if (imask_en && ibit)    allow[P_EX] = 1'b0;
            end
        end else begin : g_open
            logic unused_in;
            assign unused_in = ^{ckey, dmask, imask, imask_en};
            assign allow = PERM_ALL;
        end
    endgenerate
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import pac_pkg::*;
#(
    parameter int NUM_KEYS = 32,
    parameter bit KEY_EN   = 1'b1,
    localparam int KEY_W   = $clog2(NUM_KEYS),
    localparam int MASK_W  = 2 * NUM_KEYS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         acc_type,
    input  logic               user_mode,
    input  logic               seg_key_sup,
    input  logic               seg_key_user,
    input  logic               pte_noexec,
    input  logic               pte_guard,
    input  logic [1:0]         pte_pp,
    input  logic               pte_pp_hi,
    input  logic [KEY_W-1:0]   pte_ckey,
    input  logic [MASK_W-1:0]  dmask,
    input  logic [MASK_W-1:0]  imask,
    input  logic               imask_en,
    output logic               rsp_valid,
    output logic [PERM_W-1:0]  perm,
    output logic               grant,
    output logic [CAUSE_W-1:0] cause
);
    logic [PERM_W-1:0] guard_allow, auth_allow, key_allow;
    logic [PERM_W-1:0] need, combined;
    result_t res_d, res_q;

    pac_guard_src u_guard (
        .noexec (pte_noexec),
        .guarded(pte_guard),
        .allow  (guard_allow)
    );

    pac_auth_src u_auth (
        .user_mode(user_mode),
        .key_sup  (seg_key_sup),
        .key_user (seg_key_user),
        .code     ({pte_pp_hi, pte_pp}),
        .allow    (auth_allow)
    );

    pac_key_src #(
        .NUM_KEYS(NUM_KEYS),
        .KEY_EN  (KEY_EN)
    ) u_key (
        .ckey    (pte_ckey),
        .dmask   (dmask),
        .imask   (imask),
        .imask_en(imask_en),
        .allow   (key_allow)
    );

    always_comb begin
        unique case (acc_e'(acc_type))
            ACC_FETCH: need = 3'b100;
            ACC_STORE: need = 3'b010;
            default:   need = 3'b001;
        endcase
        combined    = guard_allow & auth_allow & key_allow;
        res_d       = '0;
        res_d.valid = req_valid;
        res_d.perm  = combined;
        res_d.grant = (need & ~combined) == '0;
        if (!res_d.grant) begin
            if (acc_e'(acc_type) == ACC_FETCH) begin
                if (!guard_allow[P_EX])     res_d.cause[C_NXG]  = 1'b1;
                else if (!auth_allow[P_EX]) res_d.cause[C_AUTH] = 1'b1;
                if (!key_allow[P_EX])       res_d.cause[C_KEY]  = 1'b1;
            end else begin
                if ((need & ~auth_allow) != '0) res_d.cause[C_AUTH] = 1'b1;
                if ((need & ~key_allow) != '0)  res_d.cause[C_KEY]  = 1'b1;
                if (acc_e'(acc_type) == ACC_STORE) res_d.cause[C_STORE] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rsp_valid = res_q.valid;
    assign perm      = res_q.perm;
    assign grant     = res_q.grant;
    assign cause     = res_q.cause;

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_only_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_guard_strips_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(pte_noexec || pte_guard) |-> !perm[P_EX]);
    assert_fetch_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && ($past(acc_type) == 2'd0) |-> !cause[C_STORE]);
    assert_grant_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && grant |-> cause == '0);
    assert_deny_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !grant |-> cause != '0);
    assert_store_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !grant && ($past(acc_type) == 2'd2) |-> cause[C_STORE]);
endmodule

// File: tb/page_perm_check_bench.sv
module page_perm_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        user_mode = 1'b0, seg_key_sup = 1'b0, seg_key_user = 1'b0;
    logic        pte_noexec = 1'b0, pte_guard = 1'b0, pte_pp_hi = 1'b0;
    logic [1:0]  pte_pp = '0;
    logic [4:0]  pte_ckey = '0;
    logic [63:0] dmask = '0, imask = '0;
    logic        imask_en = 1'b0;

    logic        rv_a, gr_a, rv_b, gr_b;
    logic [2:0]  pm_a, pm_b;
    logic [3:0]  cs_a, cs_b;

    int checks = 0, errors = 0, cyc = 0;

    typedef struct {
        int         due;
        string      tag;
        logic [2:0] pm_a;
        logic       gr_a;
        logic [3:0] cs_a;
        logic [2:0] pm_b;
        logic       gr_b;
        logic [3:0] cs_b;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    page_perm_check u_page_perm_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
        .user_mode(user_mode), .seg_key_sup(seg_key_sup), .seg_key_user(seg_key_user),
        .pte_noexec(pte_noexec), .pte_guard(pte_guard), .pte_pp(pte_pp),
        .pte_pp_hi(pte_pp_hi), .pte_ckey(pte_ckey), .dmask(dmask), .imask(imask),
        .imask_en(imask_en), .rsp_valid(rv_a), .perm(pm_a), .grant(gr_a), .cause(cs_a)
    );

    page_perm_check #(.KEY_EN(1'b0)) u_page_perm_check_nokey (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
        .user_mode(user_mode), .seg_key_sup(seg_key_sup), .seg_key_user(seg_key_user),
        .pte_noexec(pte_noexec), .pte_guard(pte_guard), .pte_pp(pte_pp),
        .pte_pp_hi(pte_pp_hi), .pte_ckey(pte_ckey), .dmask(dmask), .imask(imask),
        .imask_en(imask_en), .rsp_valid(rv_b), .perm(pm_b), .grant(gr_b), .cause(cs_b)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected result built from the requirement tables
    function automatic void model(input bit keyed, output logic [2:0] pm,
                                  output logic gr, output logic [3:0] cs);
        logic       ak;
        logic [2:0] code, g, a, k, nd;
        int         pos;
        ak   = user_mode ? seg_key_user : seg_key_sup;          // R3
        code = {pte_pp_hi, pte_pp};
        a    = 3'b000;
        if (ak == 1'b0) begin                                   // R4
            if (code inside {0, 1, 2, 6}) a = 3'b111;
            if (code inside {3, 5})       a = 3'b101;
        end else begin                                          // R5
            if (code == 2)                a = 3'b111;
            if (code inside {1, 3, 5})    a = 3'b101;
        end
        g   = (pte_noexec || pte_guard) ? 3'b011 : 3'b111;      // R2
        k   = 3'b111;
        pos = 2 * (31 - int'(pte_ckey));                        // R6
        if (keyed) begin
            if (dmask[pos + 1]) k[1] = 1'b0;
            if (dmask[pos])     k[0] = 1'b0;
            if (imask_en && imask[pos]) k[2] = 1'b0;            // R7
        end
        nd = (acc_type == 2'd0) ? 3'b100 : (acc_type == 2'd2) ? 3'b010 : 3'b001;
        pm = g & a & k;                                         // R8
        gr = (pm & nd) == nd;
        cs = 4'b0000;
        if (!gr) begin
            if (acc_type == 2'd0) begin                         // R9
                if (!g[2])      cs[0] = 1'b1;
                else if (!a[2]) cs[1] = 1'b1;
                if (!k[2])      cs[2] = 1'b1;
            end else begin                                      // R10
                cs[1] = (a & nd) != nd;
                cs[2] = (k & nd) != nd;
                cs[3] = acc_type == 2'd2;
            end
        end
    endfunction

    task automatic drive(input string tag, input logic [1:0] acc, input logic um,
                         input logic ks, input logic ku, input logic nx, input logic gd,
                         input logic [2:0] code, input logic [4:0] ck,
                         input logic [63:0] dm, input logic [63:0] im, input logic ie);
        item_t it;
        @(negedge clk);
        acc_type = acc; user_mode = um; seg_key_sup = ks; seg_key_user = ku;
        pte_noexec = nx; pte_guard = gd; {pte_pp_hi, pte_pp} = code;
        pte_ckey = ck; dmask = dm; imask = im; imask_en = ie; req_valid = 1'b1;
        it.due = cyc + 1;
        it.tag = tag;
        model(1'b1, it.pm_a, it.gr_a, it.cs_a);
        model(1'b0, it.pm_b, it.gr_b, it.cs_b);
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares at falling edges once reset is released
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sb.size() > 0 && sb[0].due == cyc) begin
                    item_t it;
                    it = sb.pop_front();
                    check({"R1 valid ", it.tag}, {7'd0, rv_a}, 8'd1);
                    check({"R8 perm ", it.tag}, {5'd0, pm_a}, {5'd0, it.pm_a});
                    check({"R8 grant ", it.tag}, {7'd0, gr_a}, {7'd0, it.gr_a});
                    check({"R9/R10 cause ", it.tag}, {4'd0, cs_a}, {4'd0, it.cs_a});
                    check({"R11 nokey ", it.tag}, {rv_b, pm_b, gr_b, cs_b[2:0]},
                          {1'b1, it.pm_b, it.gr_b, it.cs_b[2:0]});
                end else begin
                    check("R1 idle valid", {6'd0, rv_a, rv_b}, 8'd0);
                end
            end
        end
    end

    initial begin
        #1_200_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] m;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rv_a, pm_a, gr_a, cs_a[2:0]}, 8'd0);
        rst_n = 1'b1;
        idle();
        // R4 / R5 full code tables, loads and stores and fetches, privileged key
        for (int key = 0; key < 2; key++)
            for (int c = 0; c < 8; c++)
                for (int acc = 0; acc < 3; acc++)
                    drive("R4_R5 table", 2'(acc), 1'b0, 1'(key), 1'(1 - key), 1'b0, 1'b0,
                          3'(c), 5'd7, '0, '0, 1'b0);
        idle(); idle();
        // R3 key select: unprivileged uses user key
        drive("R3 user key1", 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 5'd0, '0, '0, 1'b0);
        drive("R3 user key0", 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 5'd0, '0, '0, 1'b0);
        // R2 guard / noexec
        drive("R2 noexec fetch", 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 5'd0, '0, '0, 1'b0);
        drive("R2 guard store", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 5'd0, '0, '0, 1'b0);
        drive("R9 guard+auth fetch", 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 5'd0, '0, '0, 1'b0);
        // R6 data mask positions for several keys
        for (int ck = 0; ck < 32; ck += 5) begin
            m = 64'd0;
            m[2 * (31 - ck) + 1] = 1'b1;
            drive("R6 write bit", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), m, '0, 1'b0);
            drive("R6 write bit load", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), m, '0, 1'b0);
            m = 64'd0;
            m[2 * (31 - ck)] = 1'b1;
            drive("R6 read bit", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), m, '0, 1'b0);
            drive("R6 exec kept", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), ~64'd0, '0, 1'b0);
        end
        drive("R6 other key", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd3, 64'h3, '0, 1'b0);
        drive("R6 key31 field", 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'd31, 64'h1, '0, 1'b0);
        // R7 instruction mask, enabled and disabled
        for (int ck = 0; ck < 32; ck += 7) begin
            m = 64'd0;
            m[2 * (31 - ck)] = 1'b1;
            drive("R7 imask on", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), '0, m, 1'b1);
            drive("R7 imask off", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), '0, m, 1'b0);
            drive("R7 high bit", 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 5'(ck), '0, m << 1, 1'b1);
        end
        // R9 all three fetch sources; R10 both data sources with store flag
        drive("R9 all deny", 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 5'd0, '0, ~64'd0, 1'b1);
        drive("R9 auth+key", 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 5'd0, '0, ~64'd0, 1'b1);
        drive("R10 both store", 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 5'd0, ~64'd0, '0, 1'b0);
        drive("R10 acc3 load", 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 5'd9, ~64'd0, '0, 1'b0);
        idle(); idle(); idle();
        if (sb.size() != 0) check("R1 drained", 8'(sb.size()), 8'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule